// File: doc/BRIEF.md
# Strobed Three-Value Sequence Detector

This block watches a stream of 16-bit positive integers that arrive one word at a time. A word is taken in only on a cycle where the one-cycle enter strobe is high. The data bus is ignored on every other cycle. The block raises a single `found` flag when the three most recently sampled words are 2, then 4, then 7, in that order.

The detector is a four-state machine: idle, seen-2, seen-2-4 and found. It moves only on strobe cycles. A sampled 2 always restarts a partial match, so overlapping attempts such as 2,2,4,7 are still caught. Any other word that does not extend the current match sends the machine back to idle.

`found` comes from a register. It changes on the clock edge that samples the strobe and holds between strobes. The three target words are parameters, and their default values are 2, 4 and 7. The upstream logic must supply a clean single-cycle strobe.

Top module: `seqdet_top`

## Requirements
- R1: While `rst` is high at a clock edge, the machine returns to idle and `found` is 0 after that edge.
- R2: On a cycle with `enter` low, neither `found` nor the match progress changes, whatever value is on `data_in`.
- R3: When 2, 4 and 7 are sampled on three successive strobes, `found` is 1 right after the clock edge that samples the 7.
- R4: While `found` is 1, the next strobe clears it whatever the sampled value is. A sampled 2 leaves the machine in seen-2, so a following 4,7 sets `found` again.
- R5: A sampled 2 from any state restarts the match. For example, 2,2,4,7 and 2,4,2,4,7 both set `found`.
- R6: A sampled word that neither extends the current partial match nor equals 2 returns the machine to idle. For example, 2,4,5,7 and 2,5,4,7 do not set `found`.
- R7: `enter` high on back-to-back cycles counts as one sample per cycle.
- R8: `found` stays 1 for as long as no further strobe arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 16 | Word offered for sampling |
| enter | input | 1 | One-cycle sample strobe |
| found | output | 1 | High while the last three samples are 2, 4, 7 |

## Verification
Every result is due one edge after its stimulus. The `found` register is updated on the same rising edge that sees `enter` high, so its new value is visible from that edge on. The bench drives `data_in` and `enter` at the falling edge and releases the strobe at the next falling edge. It reads `found` at that same falling edge, half a period after the sampling edge. To test that idle cycles have no effect, the bench holds the strobe low for several cycles with a matching word on the bus and reads `found` at each falling edge.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;
  localparam int DATA_W  = 16;
  localparam int PAT_LEN = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ONE   = 2'd1,
    ST_TWO   = 2'd2,
    ST_MATCH = 2'd3
  } match_st_t;
endpackage

// File: rtl/seqdet_cmp.sv
module seqdet_cmp #(
  parameter int WIDTH = 16,
  parameter int COUNT = 3,
  parameter logic [COUNT*WIDTH-1:0] TARGETS = '0
) (
  input  logic [WIDTH-1:0] word,
  output logic [COUNT-1:0] hit
);
  // hit[i] is set when the word equals target number i (target 0 is first in order)
  for (genvar i = 0; i < COUNT; i++) begin : g_cmp
    assign hit[i] = (word == TARGETS[i*WIDTH +: WIDTH]);
  end
endmodule

// File: rtl/seqdet_fsm.sv
module seqdet_fsm
  import seqdet_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       take,
  input  logic [2:0] hit,
  output logic       match_q
);
  match_st_t cur, nxt;

  always_comb begin
    nxt = cur;
    if (take) begin
      if (hit[0]) begin
        nxt = ST_ONE;
      end else begin
        unique case (cur)
          ST_ONE:  nxt = hit[1] ? ST_TWO   : ST_IDLE;
          ST_TWO:  nxt = hit[2] ? ST_MATCH : ST_IDLE;
          default: nxt = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur     <= ST_IDLE;
      match_q <= 1'b0;
    end else begin
      cur     <= nxt;
      match_q <= (nxt == ST_MATCH);
    end
  end
endmodule

// File: rtl/seqdet_top.sv
module seqdet_top
  import seqdet_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter logic [DW-1:0] FIRST  = 2,
  parameter logic [DW-1:0] SECOND = 4,
  parameter logic [DW-1:0] THIRD  = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] data_in,
  input  logic          enter,
  output logic          found
);
  localparam logic [PAT_LEN*DW-1:0] TARGETS = {THIRD, SECOND, FIRST};

  logic [PAT_LEN-1:0] hit;

  seqdet_cmp #(.WIDTH(DW), .COUNT(PAT_LEN), .TARGETS(TARGETS)) cmp_i (
    .word(data_in),
    .hit (hit)
  );

  seqdet_fsm fsm_i (
    .clk    (clk),
    .rst    (rst),
    .take   (enter),
    .hit    (hit),
    .match_q(found)
  );
endmodule

// File: rtl/seqdet_chk.sv
module seqdet_chk #(
  parameter int DW = 16,
  parameter logic [DW-1:0] FIRST = 2,
  parameter logic [DW-1:0] THIRD = 7
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] data_in,
  input logic          enter,
  input logic          found
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> !found);
  // R2
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !enter |=> $stable(found));
  // R3
  a_r3_rise_on_third: assert property (@(posedge clk) disable iff (rst)
    !found && enter && data_in != THIRD |=> !found);
  // R4
  a_r4_strobe_clears: assert property (@(posedge clk) disable iff (rst)
    found && enter |=> !found);
  // R5
  a_r5_first_restarts: assert property (@(posedge clk) disable iff (rst)
    enter && data_in == FIRST |=> !found);
endmodule

bind seqdet_top seqdet_chk #(.DW(DW), .FIRST(FIRST), .THIRD(THIRD)) chk_i (
  .clk(clk), .rst(rst), .data_in(data_in), .enter(enter), .found(found)
);

// File: tb/seqdet_top_tb.sv
module seqdet_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] data_in = '0;
  logic        enter = 1'b0;
  logic        found;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seqdet_top dut_i (.clk(clk), .rst(rst), .data_in(data_in), .enter(enter), .found(found));

  task automatic check(input string req, input logic exp);
    total++;
    if (found !== exp) begin
      bad++;
      $display("FAIL %s found=%0b expected=%0b", req, found, exp);
    end
  endtask

  // one strobe; returns at the falling edge after the sampling edge
  task automatic push(input logic [15:0] v);
    @(negedge clk);
    data_in = v;
    enter = 1'b1;
    @(negedge clk);
    enter = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 after reset", 1'b0);
    push(2); push(4); push(7);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset clears found", 1'b0);
  endtask

  task automatic t_basic();
    do_reset();
    push(2); check("R3 after 2", 1'b0);
    push(4); check("R3 after 4", 1'b0);
    push(7); check("R3 after 7", 1'b1);
  endtask

  task automatic t_ignore();
    do_reset();
    push(2); push(4);
    data_in = 7;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R2 no strobe no effect", 1'b0);
    end
    data_in = 9;
    @(negedge clk);
    push(7); check("R2 progress kept", 1'b1);
  endtask

  task automatic t_hold_and_leave();
    do_reset();
    push(2); push(4); push(7);
    data_in = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R8 found holds", 1'b1);
    end
    push(7); check("R4 strobe clears", 1'b0);
    push(2); push(4); push(7);
    push(2); check("R4 cleared by 2", 1'b0);
    push(4); push(7); check("R4 2 kept progress", 1'b1);
  endtask

  task automatic t_restart();
    do_reset();
    push(2); push(2); push(4); push(7); check("R5 2,2,4,7", 1'b1);
    do_reset();
    push(2); push(4); push(2); push(4); push(7); check("R5 2,4,2,4,7", 1'b1);
  endtask

  task automatic t_mismatch();
    do_reset();
    push(2); push(4); push(5); push(7); check("R6 2,4,5,7", 1'b0);
    push(2); push(5); push(4); push(7); check("R6 2,5,4,7", 1'b0);
    push(4); push(7); check("R6 4,7 alone", 1'b0);
  endtask

  task automatic t_burst();
    do_reset();
    @(negedge clk);
    enter = 1'b1;
    data_in = 2;
    @(negedge clk);
    data_in = 4;
    @(negedge clk);
    data_in = 7;
    @(negedge clk);
    enter = 1'b0;
    check("R7 back-to-back strobes", 1'b1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_ignore();
    t_hold_and_leave();
    t_restart();
    t_mismatch();
    t_burst();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired found=%0b expected=done", found);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule